// File: doc/BRIEF.md
# UTMI Transmit Packet Sender

This block sits between a byte-wide streaming packet source and the 8-bit transmit side of a UTMI PHY. The source offers bytes with a valid/ready handshake and marks the final byte of each packet with a last flag. The block copies each byte into a holding register and presents it to the PHY. It keeps the byte there until the PHY signals acceptance with its ready line. The transmit valid line stays high from the first byte of a packet to its last byte. When valid drops, the packet has ended.

The cycle after valid drops is an end-of-packet cycle. In that cycle the PHY is required to hold ready high. If it does not, the block sets a sticky error flag, and only reset clears that flag. The block also enforces an idle gap between packets. Valid stays low for the end-of-packet cycle, then for `GAP_EXTRA` more cycles, then for the cycle in which the next first byte is taken. Out of reset, all PHY-facing outputs are at their idle values.

The source must keep its valid line high inside a packet. It may drop valid only between packets.

Top module: `utmi_tx_sender`

## Requirements
- R1: After synchronous reset, `tx_valid` is 0, `tx_data` is 0 and `eop_err` is 0.
- R2: In idle, once the gap has elapsed, `s_tready` is high. A byte offered there is taken, and on the next cycle `tx_valid` is 1 with that byte on `tx_data`.
- R3: `tx_valid` stays 1 from the first byte up to and including the cycle in which the PHY accepts the byte whose last flag is set. Bytes reach the PHY in source order.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` does not change on the next cycle.
- R5: While `tx_valid` is 1, `s_tready` equals `tx_ready`, except that it is 0 while the byte on `tx_data` carries the last flag.
- R6: The cycle after the PHY accepts a last byte is the end-of-packet cycle. In it `tx_valid` is 0 and `s_tready` is 0.
- R7: If `tx_ready` is 0 during the end-of-packet cycle, `eop_err` becomes 1 on the next cycle and stays 1 until reset. If `tx_ready` is 1 there, `eop_err` is unchanged.
- R8: Between two packets, `tx_valid` is low for at least 2 + `GAP_EXTRA` consecutive cycles, and `s_tready` is 0 for the first 1 + `GAP_EXTRA` of them.
- R9: A reset asserted in the middle of a packet returns the block to idle with `tx_valid` 0 and `eop_err` cleared.
- R10: Whenever `tx_valid` is 0, `tx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Source byte |
| s_tlast | input | 1 | Source byte is the last of its packet |
| s_tvalid | input | 1 | Source byte valid |
| s_tready | output | 1 | Block takes the source byte this cycle |
| tx_valid | output | 1 | Packet in progress toward the PHY |
| tx_data | output | 8 | Byte presented to the PHY |
| tx_ready | input | 1 | PHY accepts the current byte / end-of-packet acknowledge |
| eop_err | output | 1 | Sticky: PHY missed the end-of-packet acknowledge |

## Verification
Suppose the control state is wrong, for example still sending after the last byte. Then `tx_valid` stays high one cycle too long, or `s_tready` rises during the gap, and this shows in the very next cycle. A corrupted or early-advanced holding register shows up on `tx_data` while ready is low, or at the next PHY acceptance as a byte out of source order. An error flag that leaks or clears on its own shows in `eop_err` one cycle after the end-of-packet cycle. Because of that, the PHY model deliberately withholds the acknowledge in some packets.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int unsigned UTX_DATA_W = 8;

    typedef enum logic [1:0] {
        UTX_IDLE = 2'd0,
        UTX_SEND = 2'd1,
        UTX_EOP  = 2'd2
    } utx_state_e;

    typedef struct packed {
        logic [UTX_DATA_W-1:0] data;
        logic                  last;
    } utx_beat_t;

    function automatic int unsigned utx_gap_width(input int unsigned extra);
        return (extra > 0) ? $clog2(extra + 1) : 1;
    endfunction

endpackage

// File: rtl/utx_hold.sv
module utx_hold
    import utx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  utx_beat_t beat_in,
    output utx_beat_t beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= beat_in;
        end
    end

endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
    import utx_pkg::*;
#(
    parameter int unsigned GAP_EXTRA = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic src_valid,
    input  logic phy_ready,
    input  logic held_last,
    output logic src_ready,
    output logic load,
    output logic send_active,
    output logic err_q
);

    localparam int unsigned GW = utx_gap_width(GAP_EXTRA);

    utx_state_e      state_q, state_d;
    logic [GW-1:0]   gap_q;
    logic            gap_done;

    assign gap_done = (gap_q == '0);

    always_comb begin
        state_d   = state_q;
        src_ready = 1'b0;
        case (state_q)
            UTX_IDLE: begin
                src_ready = gap_done;
                if (gap_done && src_valid) state_d = UTX_SEND;
            end
            UTX_SEND: begin
                src_ready = phy_ready && !held_last;
                if (phy_ready && held_last) state_d = UTX_EOP;
            end
            UTX_EOP: begin
                state_d = UTX_IDLE;
            end
            default: state_d = UTX_IDLE;
        endcase
    end

    assign load        = src_ready && src_valid;
    assign send_active = (state_q == UTX_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UTX_IDLE;
            gap_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == UTX_EOP) begin
                gap_q <= GW'(GAP_EXTRA);
                if (!phy_ready) err_q <= 1'b1;
            end else if (state_q == UTX_IDLE && !gap_done) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/utmi_tx_sender.sv
module utmi_tx_sender
    import utx_pkg::*;
#(
    parameter int unsigned GAP_EXTRA = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [UTX_DATA_W-1:0] s_tdata,
    input  logic                  s_tlast,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    output logic                  tx_valid,
    output logic [UTX_DATA_W-1:0] tx_data,
    input  logic                  tx_ready,
    output logic                  eop_err
);

    utx_beat_t in_beat, held;
    logic      load;

    assign in_beat.data = s_tdata;
    assign in_beat.last = s_tlast;

    utx_ctrl #(.GAP_EXTRA(GAP_EXTRA)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .src_valid   (s_tvalid),
        .phy_ready   (tx_ready),
        .held_last   (held.last),
        .src_ready   (s_tready),
        .load        (load),
        .send_active (tx_valid),
        .err_q       (eop_err)
    );

    utx_hold hold_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .beat_in (in_beat),
        .beat_q  (held)
    );

    assign tx_data = tx_valid ? held.data : '0;

endmodule

// File: rtl/utx_sender_chk.sv
module utx_sender_chk
    import utx_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  s_tready,
    input logic                  tx_valid,
    input logic [UTX_DATA_W-1:0] tx_data,
    input logic                  tx_ready,
    input logic                  eop_err
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R3
    valid_fall_needs_accept_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(tx_valid) |-> $past(tx_ready));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R5
    src_ready_follows_phy_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (tx_valid && s_tready) |-> tx_ready);

    // R6
    eop_cycle_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(tx_valid) |-> !s_tready);

    // R8
    min_gap_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(tx_valid) |=> !tx_valid);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        eop_err |=> eop_err);

    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(eop_err) |-> ($past(!tx_ready) && !$past(tx_valid)));

    // R10
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !tx_valid |-> (tx_data == '0));

endmodule

bind utmi_tx_sender utx_sender_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .s_tready (s_tready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .eop_err  (eop_err)
);

// File: tb/utmi_tx_sender_test.sv
module utmi_tx_sender_test;

    localparam int GAP = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] s_tdata = '0;
    logic       s_tlast = 1'b0;
    logic       s_tvalid = 1'b0;
    logic       s_tready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       eop_err;

    always #5 clk = ~clk;

    utmi_tx_sender #(.GAP_EXTRA(GAP)) uut (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .eop_err(eop_err)
    );

    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    logic [7:0] q_data[$];
    bit   q_last[$];
    int   src_i, phy_i;
    bit   prev_txv, prev_rdy, prev_last, exp_err;
    logic [7:0] prev_data;
    int   low_run;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_src_ready(input bit rdy, input bit last_held);
        return rdy && !last_held;
    endfunction

    task automatic clear_model();
        q_data.delete(); q_last.delete();
        src_i = 0; phy_i = 0;
        prev_txv = 0; prev_rdy = 0; prev_last = 0; prev_data = '0;
        low_run = 100; exp_err = 0;
    endtask

    task automatic add_packet(input int len);
        for (int k = 0; k < len; k++) begin
            q_data.push_back(8'($urandom));
            q_last.push_back(k == len - 1);
        end
    endtask

    // bad_mode: 0 acknowledge always, 1 never acknowledge, 2 random
    task automatic step(input int bad_mode);
        bit eop_cyc, cur_last;
        @(negedge clk);
        eop_cyc  = prev_txv && !tx_valid;
        s_tvalid = (src_i < q_data.size());
        s_tdata  = s_tvalid ? q_data[src_i] : 8'h00;
        s_tlast  = s_tvalid ? q_last[src_i] : 1'b0;
        if (eop_cyc)
            tx_ready = (bad_mode == 1) ? 1'b0 : (bad_mode == 2) ? ($urandom % 3 != 0) : 1'b1;
        else
            tx_ready = ($urandom % 4 != 0);
        #1;
        cur_last = prev_last;
        // R10
        if (!tx_valid) chk(tx_data == 8'h00, "R10 idle data", tx_data, 0);
        // R4
        if (prev_txv && !prev_rdy)
            chk(tx_valid && tx_data == prev_data, "R4 byte held", tx_data, prev_data);
        // R3
        if (prev_txv && prev_rdy && !prev_last)
            chk(tx_valid == 1'b1, "R3 valid through packet", tx_valid, 1);
        // R6
        if (prev_txv && prev_rdy && prev_last)
            chk(tx_valid == 1'b0, "R6 valid drops after last", tx_valid, 0);
        if (eop_cyc) chk(s_tready == 1'b0, "R6 eop tready", s_tready, 0);
        // R8 and R2
        if (tx_valid && !prev_txv) begin
            chk(low_run >= 2 + GAP, "R8 idle gap", low_run, 2 + GAP);
            if (phy_i < q_data.size())
                chk(tx_data == q_data[phy_i], "R2 first byte", tx_data, q_data[phy_i]);
        end
        if (!tx_valid && low_run < 1 + GAP && !eop_cyc)
            chk(s_tready == 1'b0, "R8 tready in gap", s_tready, 0);
        // R5
        if (tx_valid && phy_i < q_data.size())
            chk(s_tready == exp_src_ready(tx_ready, q_last[phy_i]), "R5 tready",
                s_tready, exp_src_ready(tx_ready, q_last[phy_i]));
        if (tx_valid && tx_ready) begin
            if (phy_i < q_data.size()) begin
                chk(tx_data == q_data[phy_i], "R3 byte order", tx_data, q_data[phy_i]);
                cur_last = q_last[phy_i];
            end else begin
                chk(1'b0, "R3 extra byte", tx_data, -1);
            end
            phy_i++;
        end
        // R7
        chk(eop_err == exp_err, "R7 error flag", eop_err, exp_err);
        if (s_tvalid && s_tready) src_i++;
        if (eop_cyc && !tx_ready) exp_err = 1;
        prev_txv = tx_valid; prev_rdy = tx_ready; prev_data = tx_data;
        prev_last = cur_last;
        low_run = tx_valid ? 0 : low_run + 1;
    endtask

    task automatic drain(input int bad_mode);
        int guard = 0;
        while (!(phy_i >= q_data.size() && low_run >= 3 + GAP) && guard < 5000) begin
            step(bad_mode);
            guard++;
        end
        chk(phy_i == q_data.size(), "R3 all bytes delivered", phy_i, q_data.size());
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0; tx_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(tx_valid == 1'b0, req, tx_valid, 0);
        chk(tx_data == 8'h00, req, tx_data, 0);
        chk(eop_err == 1'b0, req, eop_err, 0);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        void'($urandom(32'd1234));
        clear_model();
        // R1
        do_reset("R1 reset state");
        // R7 directed: single byte packet, acknowledge withheld
        add_packet(1);
        drain(1);
        chk(eop_err == 1'b1, "R7 error set", eop_err, 1);
        // R7 sticky through good packets
        for (int p = 0; p < 20; p++) add_packet(1 + $urandom % 6);
        drain(0);
        chk(eop_err == 1'b1, "R7 error sticky", eop_err, 1);
        // R9: reset in the middle of a packet
        do_reset("R9 pre");
        add_packet(8);
        for (int c = 0; c < 5; c++) step(0);
        do_reset("R9 mid-packet reset");
        // random traffic, acknowledge good
        for (int p = 0; p < 40; p++) add_packet(1 + $urandom % 7);
        drain(0);
        // random traffic with random missing acknowledges
        do_reset("R1 reset again");
        for (int p = 0; p < 40; p++) add_packet(1 + $urandom % 5);
        drain(2);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule